// File: doc/BRIEF.md
# Periodic Timebase with Interrupt Flags and Watchdog Reset

The block is a free-running timebase clocked by the oscillator. A three-bit prescaler that divides by eight feeds a chain of counter stages. Together they form a single binary count. The eight stages just above the prescaler can be read at any time as a byte.

Taps on the same count produce three things:
- a fixed overflow flag, set whenever that byte wraps;
- a real-time interrupt flag whose period is chosen by a two-bit code;
- a watchdog that counts real-time interrupt periods.

Each flag has its own enable input and its own acknowledge input. The interrupt request output is the OR of the flags that are enabled.

Software must strobe the watchdog clear input within seven to eight interrupt periods. If it does not, the block drives its system reset output. The block also sequences reset release after power-on. While the power-on input is high, the count is held at zero. Once that input falls, the count runs until a startup delay has passed. The option input selects a short or a long delay, counted in bus cycles of two oscillator cycles each. The count is then cleared and the reset output falls. A watchdog timeout runs the same release sequence.

Top module: `rtw_timebase`

## Requirements
- R1: The count advances by one on every oscillator cycle. `tick_byte` equals the count shifted right by three, modulo 256. After reset release, `tick_byte` reads floor(k/8) mod 256 at oscillator cycle k. The byte has no write path.
- R2: While `por_in` is high, the count is zero and `sys_rst` is 1. Both flags and `irq` are 0. Raising `por_in` mid-run restores this state at once.
- R3: `ovf_flag` sets once every 2^11 oscillator cycles, on the edge where `tick_byte` wraps from 255 to 0. It stays set until it is acknowledged.
- R4: The code on `rate_sel` picks the real-time interrupt period as 2^(PRE_BITS+STAGES-3+code) oscillator cycles. At the default sizes, codes 0, 1, 2 and 3 give 2^15, 2^16, 2^17 and 2^18 cycles. `rti_flag` sets at the end of each period, counted from reset release.
- R5: Each flag clears on the edge after a cycle where its acknowledge input is 1. If a set and an acknowledge fall on the same edge, the set wins. `irq` = (`ovf_flag` AND `ovf_en`) OR (`rti_flag` AND `rti_en`).
- R6: A 3-bit watchdog counter advances on each real-time interrupt tick. `cop_clr` zeroes this counter only, and takes priority over a tick in the same cycle. The 8th tick after the last clear (or after release) is a timeout. A timeout raises `sys_rst` and zeroes the count.
- R7: `dly_long` = 0 selects 16 bus cycles (32 oscillator cycles) of startup delay. `dly_long` = 1 selects 4064 bus cycles (8128 oscillator cycles). `sys_rst` falls that many oscillator cycles after `por_in` falls or after a watchdog timeout.
- R8: On the edge where `sys_rst` falls, the count is cleared, so `tick_byte` reads 0 in the first released cycle.
- R9: While `sys_rst` is high, both flags are held at 0 and the watchdog counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_in | input | 1 | Power-on reset, active high, asynchronous |
| dly_long | input | 1 | Startup delay option: 0 short, 1 long |
| rate_sel | input | 2 | Real-time interrupt period code |
| ovf_en | input | 1 | Overflow flag interrupt enable |
| rti_en | input | 1 | Real-time flag interrupt enable |
| ovf_ack | input | 1 | Write-one acknowledge for the overflow flag |
| rti_ack | input | 1 | Write-one acknowledge for the real-time flag |
| cop_clr | input | 1 | Watchdog clear strobe |
| tick_byte | output | 8 | Read-only view of the eight stages above the prescaler |
| ovf_flag | output | 1 | Overflow flag |
| rti_flag | output | 1 | Real-time interrupt flag |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | System reset, active high |

## Verification
The assertions assume three things about the inputs:
- `por_in` is high from time zero until after the first clock edge.
- `dly_long` and `rate_sel` change only while the block is in reset, or at least well away from the tap edges.
- The power-on input is the only source of asynchronous reset.

The stimulus follows this. It sets `rate_sel` and the delay option while `por_in` is held high, and it changes `dly_long` only mid-run, long before a timeout uses it. All acknowledge and clear strobes are one-cycle pulses, driven just after a clock edge.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

  localparam int FLG_OVF = 0;
  localparam int FLG_RTI = 1;
  localparam int FLG_N   = 2;

  // Exponent of the shortest real-time period; the longest code uses the
  // full chain width.
  function automatic int rti_base(input int chain_w, input int rate_w);
    return chain_w - (1 << rate_w) + 1;
  endfunction

  // Startup delay expressed in oscillator cycles.
  function automatic int osc_cycles(input int bus_cycles, input int bus_div);
    return bus_cycles * bus_div;
  endfunction

endpackage

// File: rtl/rtw_chain.sv
module rtw_chain #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         por,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or posedge por) begin
    if (por)      cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rtw_taps.sv
module rtw_taps #(
  parameter int W        = 18,
  parameter int OVF_BITS = 11,
  parameter int RTI_BASE = 15,
  parameter int RATE_W   = 2
) (
  input  logic [W-1:0]      cnt,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              run,
  output logic              ovf_tick,
  output logic              rti_tick
);

  localparam int NRATE = 1 << RATE_W;

  logic [NRATE-1:0] cand;

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    assign cand[g] = &cnt[RTI_BASE+g-1:0];
  end

  assign ovf_tick = run & (&cnt[OVF_BITS-1:0]);
  assign rti_tick = run & cand[rate_sel];

endmodule

// File: rtl/rtw_cop.sv
module rtw_cop #(
  parameter int WD_W = 3
) (
  input  logic clk,
  input  logic por,
  input  logic run,
  input  logic rti_tick,
  input  logic clr,
  output logic timeout
);

  logic [WD_W-1:0] wd_cnt;

  assign timeout = run & rti_tick & ~clr & (&wd_cnt);

  always_ff @(posedge clk or posedge por) begin
    if (por)                         wd_cnt <= '0;
    else if (!run || clr || timeout) wd_cnt <= '0;
    else if (rti_tick)               wd_cnt <= wd_cnt + 1'b1;
  end

endmodule

// File: rtl/rtw_seq.sv
module rtw_seq #(
  parameter int W         = 18,
  parameter int SHORT_OSC = 32,
  parameter int LONG_OSC  = 8128
) (
  input  logic         clk,
  input  logic         por,
  input  logic         dly_long,
  input  logic [W-1:0] cnt,
  input  logic         timeout,
  output logic         run,
  output logic         release_evt,
  output logic         chain_clr
);

  localparam logic [W-1:0] LAST_SHORT = W'(SHORT_OSC - 1);
  localparam logic [W-1:0] LAST_LONG  = W'(LONG_OSC - 1);

  logic [W-1:0] last_cnt;

  assign last_cnt    = dly_long ? LAST_LONG : LAST_SHORT;
  assign release_evt = ~run & (cnt == last_cnt);
  assign chain_clr   = release_evt | timeout;

  always_ff @(posedge clk or posedge por) begin
    if (por)              run <= 1'b0;
    else if (release_evt) run <= 1'b1;
    else if (timeout)     run <= 1'b0;
  end

endmodule

// File: rtl/rtw_flags.sv
module rtw_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         por,
  input  logic         hold,
  input  logic [N-1:0] set,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] en,
  output logic [N-1:0] flag,
  output logic         irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or posedge por) begin
      if (por)         flag[i] <= 1'b0;
      else if (hold)   flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (ack[i]) flag[i] <= 1'b0;
    end
  end

  assign irq = |(flag & en);

endmodule

// File: rtl/rtw_timebase.sv
module rtw_timebase
  import rtw_pkg::*;
#(
  parameter int PRE_BITS  = 3,
  parameter int STAGES    = 15,
  parameter int BYTE_W    = 8,
  parameter int RATE_W    = 2,
  parameter int WD_W      = 3,
  parameter int BUS_DIV   = 2,
  parameter int DLY_SHORT = 16,
  parameter int DLY_LONG  = 4064
) (
  input  logic              clk_osc,
  input  logic              por_in,
  input  logic              dly_long,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              ovf_en,
  input  logic              rti_en,
  input  logic              ovf_ack,
  input  logic              rti_ack,
  input  logic              cop_clr,
  output logic [BYTE_W-1:0] tick_byte,
  output logic              ovf_flag,
  output logic              rti_flag,
  output logic              irq,
  output logic              sys_rst
);

  localparam int CHAIN_W   = PRE_BITS + STAGES;
  localparam int OVF_BITS  = PRE_BITS + BYTE_W;
  localparam int RTI_BASE  = rti_base(CHAIN_W, RATE_W);
  localparam int SHORT_OSC = osc_cycles(DLY_SHORT, BUS_DIV);
  localparam int LONG_OSC  = osc_cycles(DLY_LONG, BUS_DIV);

  // Named internal events, also used by the bound checker.
  logic [CHAIN_W-1:0] chain_cnt;
  logic               chain_clr;
  logic               run;
  logic               release_evt;
  logic               ovf_tick;
  logic               rti_tick;
  logic               cop_timeout;
  logic [FLG_N-1:0]   flg_set, flg_ack, flg_en, flg_q;

  rtw_chain #(.W(CHAIN_W)) u_chain (
    .clk (clk_osc),
    .por (por_in),
    .clr (chain_clr),
    .cnt (chain_cnt)
  );

  rtw_taps #(
    .W(CHAIN_W), .OVF_BITS(OVF_BITS), .RTI_BASE(RTI_BASE), .RATE_W(RATE_W)
  ) u_taps (
    .cnt      (chain_cnt),
    .rate_sel (rate_sel),
    .run      (run),
    .ovf_tick (ovf_tick),
    .rti_tick (rti_tick)
  );

  rtw_cop #(.WD_W(WD_W)) u_cop (
    .clk      (clk_osc),
    .por      (por_in),
    .run      (run),
    .rti_tick (rti_tick),
    .clr      (cop_clr),
    .timeout  (cop_timeout)
  );

  rtw_seq #(
    .W(CHAIN_W), .SHORT_OSC(SHORT_OSC), .LONG_OSC(LONG_OSC)
  ) u_seq (
    .clk         (clk_osc),
    .por         (por_in),
    .dly_long    (dly_long),
    .cnt         (chain_cnt),
    .timeout     (cop_timeout),
    .run         (run),
    .release_evt (release_evt),
    .chain_clr   (chain_clr)
  );

  always_comb begin
    flg_set          = '0;
    flg_ack          = '0;
    flg_en           = '0;
    flg_set[FLG_OVF] = ovf_tick;
    flg_set[FLG_RTI] = rti_tick;
    flg_ack[FLG_OVF] = ovf_ack;
    flg_ack[FLG_RTI] = rti_ack;
    flg_en[FLG_OVF]  = ovf_en;
    flg_en[FLG_RTI]  = rti_en;
  end

  rtw_flags #(.N(FLG_N)) u_flags (
    .clk  (clk_osc),
    .por  (por_in),
    .hold (~run | cop_timeout),
    .set  (flg_set),
    .ack  (flg_ack),
    .en   (flg_en),
    .flag (flg_q),
    .irq  (irq)
  );

  assign tick_byte = chain_cnt[PRE_BITS +: BYTE_W];
  assign ovf_flag  = flg_q[FLG_OVF];
  assign rti_flag  = flg_q[FLG_RTI];
  assign sys_rst   = ~run;

endmodule

// File: rtl/rtw_checker.sv
module rtw_checker #(
  parameter int W = 18
) (
  input logic         clk_osc,
  input logic         por_in,
  input logic [W-1:0] chain_cnt,
  input logic         chain_clr,
  input logic         ovf_tick,
  input logic         rti_tick,
  input logic         cop_timeout,
  input logic         cop_clr,
  input logic [7:0]   tick_byte,
  input logic         ovf_flag,
  input logic         rti_flag,
  input logic         irq,
  input logic         sys_rst
);

  AST_CHAIN_STEP: assert property (@(posedge clk_osc) disable iff (por_in)
    !chain_clr |=> chain_cnt == $past(chain_cnt) + 1'b1); // R1

  AST_OVF_WRAP: assert property (@(posedge clk_osc) disable iff (por_in)
    (ovf_tick && !cop_timeout) |=> (ovf_flag && tick_byte == 8'd0)); // R3

  AST_RTI_SET: assert property (@(posedge clk_osc) disable iff (por_in)
    (rti_tick && !cop_timeout) |=> rti_flag); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk_osc) disable iff (por_in)
    (!ovf_flag && !rti_flag) |-> !irq); // R5

  AST_TIMEOUT_RST: assert property (@(posedge clk_osc) disable iff (por_in)
    cop_timeout |=> (sys_rst && chain_cnt == '0)); // R6

  AST_CLR_BLOCKS: assert property (@(posedge clk_osc) disable iff (por_in)
    cop_clr |-> !cop_timeout); // R6

  AST_RELEASE_ZERO: assert property (@(posedge clk_osc) disable iff (por_in)
    $fell(sys_rst) |-> chain_cnt == '0); // R8

  AST_HOLD_FLAGS: assert property (@(posedge clk_osc) disable iff (por_in)
    sys_rst |-> (!ovf_flag && !rti_flag)); // R9

endmodule

bind rtw_timebase rtw_checker #(.W(CHAIN_W)) u_chk (
  .clk_osc     (clk_osc),
  .por_in      (por_in),
  .chain_cnt   (chain_cnt),
  .chain_clr   (chain_clr),
  .ovf_tick    (ovf_tick),
  .rti_tick    (rti_tick),
  .cop_timeout (cop_timeout),
  .cop_clr     (cop_clr),
  .tick_byte   (tick_byte),
  .ovf_flag    (ovf_flag),
  .rti_flag    (rti_flag),
  .irq         (irq),
  .sys_rst     (sys_rst)
);

// File: tb/rtw_timebase_tb.sv
module rtw_timebase_tb;

  localparam int PRE   = 3;
  localparam int STG   = 12;
  localparam int BYTEW = 8;
  localparam int OVF_P = 1 << (PRE + BYTEW);        // R3: 2^11
  localparam int D_SHORT = 32;                      // R7: 16 bus cycles
  localparam int D_LONG  = 8128;                    // R7: 4064 bus cycles

  localparam int S_RST = 0, S_BYTE = 1, S_OVF = 2, S_RTI = 3, S_IRQ = 4;

  function automatic int rti_p(input int code);     // R4
    return 1 << (PRE + STG - 3 + code);
  endfunction

  logic       clk = 1'b0;
  logic       por_in = 1'b1;
  logic       dly_long = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       ovf_en = 1'b0, rti_en = 1'b0;
  logic       ovf_ack = 1'b0, rti_ack = 1'b0, cop_clr = 1'b0;
  logic [7:0] tick_byte;
  logic       ovf_flag, rti_flag, irq, sys_rst;

  always #2 clk = ~clk;

  rtw_timebase #(.STAGES(STG)) u_dut (
    .clk_osc(clk), .por_in(por_in), .dly_long(dly_long), .rate_sel(rate_sel),
    .ovf_en(ovf_en), .rti_en(rti_en), .ovf_ack(ovf_ack), .rti_ack(rti_ack),
    .cop_clr(cop_clr), .tick_byte(tick_byte), .ovf_flag(ovf_flag),
    .rti_flag(rti_flag), .irq(irq), .sys_rst(sys_rst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    int    val;
    string tag;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad = 0;

  function automatic int observe(input int sig);
    case (sig)
      S_RST:   return int'(sys_rst);
      S_BYTE:  return int'(tick_byte);
      S_OVF:   return int'(ovf_flag);
      S_RTI:   return int'(rti_flag);
      default: return int'(irq);
    endcase
  endfunction

  // Driver side: push an expected item, kept sorted by cycle.
  task automatic expect_at(input int at, input int sig, input int val, input string tag);
    exp_t it;
    int idx;
    it.at = at; it.sig = sig; it.val = val; it.tag = tag;
    idx = 0;
    while (idx < sb.size() && sb[idx].at <= at) idx++;
    sb.insert(idx, it);
  endtask

  // Monitor side: pop and compare at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t it;
      int act;
      it = sb.pop_front();
      total++;
      act = observe(it.sig);
      if (it.at < cyc) begin
        bad++;
        $display("FAIL %s: item for cycle %0d missed (act=%0d exp=%0d)", it.tag, it.at, act, it.val);
      end else if (act != it.val) begin
        bad++;
        $display("FAIL %s: cycle %0d signal %0d act=%0d exp=%0d", it.tag, cyc, it.sig, act, it.val);
      end
    end
  end

  task automatic step_to(input int n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drain();
    while (sb.size() > 0) @(posedge clk);
    #1;
  endtask

  initial begin
    int p, rel, rel2;
    step_to(3);
    // R2: state while power-on is held
    expect_at(5, S_RST, 1, "R2");
    expect_at(5, S_BYTE, 0, "R2");
    expect_at(5, S_OVF, 0, "R2");
    expect_at(5, S_IRQ, 0, "R2");
    ovf_en = 1'b1;
    step_to(8);
    por_in = 1'b0;
    p = cyc;
    rel = p + D_LONG;
    expect_at(rel - 1, S_RST, 1, "R7");
    expect_at(rel, S_RST, 0, "R7");
    expect_at(rel, S_BYTE, 0, "R8");
    expect_at(rel + 300, S_BYTE, (300 / 8) % 256, "R1");
    expect_at(rel + OVF_P - 1, S_BYTE, 255, "R1");
    expect_at(rel + OVF_P - 1, S_OVF, 0, "R3");
    expect_at(rel + OVF_P, S_OVF, 1, "R3");
    expect_at(rel + OVF_P, S_BYTE, 0, "R3");
    expect_at(rel + OVF_P + 2, S_IRQ, 1, "R5");
    expect_at(rel + 2101, S_OVF, 0, "R5");
    expect_at(rel + 2101, S_IRQ, 0, "R5");
    expect_at(rel + 4095, S_RTI, 0, "R4");
    expect_at(rel + 4095, S_OVF, 0, "R3");
    expect_at(rel + rti_p(0), S_RTI, 1, "R4");
    expect_at(rel + 4096, S_OVF, 1, "R5");      // set wins over ack
    expect_at(rel + 9000, S_BYTE, (9000 / 8) % 256, "R1");
    expect_at(rel + 8 * rti_p(0), S_RST, 0, "R6"); // cleared, no timeout yet
    expect_at(rel + 9 * rti_p(0) - 1, S_RST, 0, "R6");
    expect_at(rel + 9 * rti_p(0), S_RST, 1, "R6");
    rel2 = rel + 9 * rti_p(0) + D_SHORT;
    expect_at(rel2 - 1, S_RST, 1, "R7");
    expect_at(rel2, S_RST, 0, "R7");
    expect_at(rel2, S_BYTE, 0, "R8");
    expect_at(rel2, S_RTI, 0, "R9");
    expect_at(rel2 + 5, S_OVF, 0, "R9");

    step_to(rel + 2100); ovf_ack = 1'b1;
    step_to(rel + 2101); ovf_ack = 1'b0;
    step_to(rel + 4095); ovf_ack = 1'b1;
    step_to(rel + 4096); ovf_ack = 1'b0;
    step_to(rel + 6096); cop_clr = 1'b1;      // R6: clear after 1st tick
    step_to(rel + 6097); cop_clr = 1'b0;
    step_to(rel + 10000); dly_long = 1'b0;
    drain();

    // R4 / R5: remaining rate codes, overflow flag masked, RTI enabled
    for (int rs = 1; rs < 4; rs++) begin
      int c;
      c = cyc;
      por_in = 1'b1;
      expect_at(c + 1, S_RST, 1, "R2");
      expect_at(c + 1, S_BYTE, 0, "R2");
      expect_at(c + 1, S_OVF, 0, "R2");
      rate_sel = 2'(rs);
      ovf_en = 1'b0;
      rti_en = 1'b1;
      step_to(c + 4);
      por_in = 1'b0;
      p = cyc;
      rel = p + D_SHORT;
      expect_at(rel, S_RST, 0, "R7");
      expect_at(rel + rti_p(rs) - 1, S_RTI, 0, "R4");
      expect_at(rel + rti_p(rs) - 1, S_OVF, 1, "R3");
      expect_at(rel + rti_p(rs) - 1, S_IRQ, 0, "R5");
      expect_at(rel + rti_p(rs), S_RTI, 1, "R4");
      expect_at(rel + rti_p(rs), S_IRQ, 1, "R5");
      drain();
    end

    step_to(cyc + 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung act=%0d exp=0 pending items", sb.size());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule